// File: doc/BRIEF.md
# Mixed Latched and Live Status Byte with Interrupt

This block holds one status byte whose bit positions are split, at build time, into two kinds. Sticky positions capture a pulse on their event input and keep the 1 until the host acknowledges it. Live positions show their condition input as it is now, with no memory. The host reads the whole byte on one port. It acknowledges events by writing a byte in which each 1 names a sticky bit to clear.

A separate enable byte picks which sticky events may raise the interrupt. The interrupt pin is active low and comes from a flop. It goes low while any enabled sticky bit is set. It goes high again once every enabled event has been acknowledged or disabled.

Top module: `stat_irq_top`

## Requirements
- R1: A 1 on `evtIn[i]` at a sticky position, sampled at a rising clock edge, makes `rdData[i]` read 1 after that edge.
- R2: When `ackWr` is high, each sticky bit with a 1 in `ackData` is cleared at the edge. Sticky bits with a 0 in `ackData` keep their value.
- R3: A sticky bit that has been cleared stays 0 until its event input is high again at a clock edge.
- R4: If an event and a clear reach the same sticky bit at the same edge, the bit ends up 1.
- R5: At a live position, `rdData[i]` equals `condIn[i]` in the same cycle. It keeps no history, and writes through `ackWr` do not change it.
- R6: Parameter `STICKY_MASK` chooses the kind of each position (1 means sticky). Its default is 8'hF0, so bits 7..4 are sticky and bits 3..0 are live.
- R7: When `enWr` is high, `enData` is loaded into the enable byte at the edge. The enable byte is shown on `enQ`.
- R8: `intN` goes low one clock edge after a sticky bit is set while its enable is 1. A sticky bit whose enable is 0 does not pull `intN` low.
- R9: `intN` goes back high one edge after no sticky bit remains with both the bit and its enable at 1.
- R10: While `rstN` is low, every sticky bit is 0, the enable byte is 0 and `intN` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| evtIn | input | 8 | Event pulses for the sticky positions |
| condIn | input | 8 | Live conditions for the live positions |
| ackWr | input | 1 | Strobe for the write-one-to-clear acknowledge |
| ackData | input | 8 | Mask of sticky bits to clear |
| enWr | input | 1 | Strobe that loads the enable byte |
| enData | input | 8 | New value for the enable byte |
| rdData | output | 8 | Status byte as read by the host |
| enQ | output | 8 | Current enable byte |
| intN | output | 1 | Registered interrupt, active low |

## Verification
The functions that can land in the same cycle are an incoming event and a host acknowledge on the same sticky bit. The bench raises `evtIn` and `ackWr` together, with a 1 at that bit in `ackData`, and expects the bit to read 1 afterwards. The same acknowledge clears a neighbouring sticky bit, which shows that the clear path was really active. A second overlap happens when the interrupt releases: one acknowledge removes the last enabled event while a disabled event is still set. `intN` must then rise even though the status byte is not all zero.

// File: rtl/stat_irq_pkg.sv
package stat_irq_pkg;
  // strobes the control side hands to the datapath each cycle
  typedef struct packed {
    logic clrValid;
    logic enLoad;
  } statStrobe_t;
endpackage

// File: rtl/stat_irq_ctrl.sv
module stat_irq_ctrl
  import stat_irq_pkg::*;
#(
  parameter int unsigned WIDTH = 8,
  parameter logic [WIDTH-1:0] STICKY_MASK = 8'hF0
) (
  input  logic             ackWr,
  input  logic [WIDTH-1:0] ackData,
  input  logic             enWr,
  output statStrobe_t      strb,
  output logic [WIDTH-1:0] clrMask
);
  always_comb begin
    strb.clrValid = ackWr;
    strb.enLoad   = enWr;
    // only sticky positions can ever be cleared (R5)
    clrMask       = ackData & STICKY_MASK;
  end
endmodule

// File: rtl/stat_irq_dp.sv
module stat_irq_dp
  import stat_irq_pkg::*;
#(
  parameter int unsigned WIDTH = 8,
  parameter logic [WIDTH-1:0] STICKY_MASK = 8'hF0
) (
  input  logic             clk,
  input  logic             rstN,
  input  statStrobe_t      strb,
  input  logic [WIDTH-1:0] clrMask,
  input  logic [WIDTH-1:0] evtIn,
  input  logic [WIDTH-1:0] condIn,
  input  logic [WIDTH-1:0] enData,
  output logic [WIDTH-1:0] rdData,
  output logic [WIDTH-1:0] enQ,
  output logic             intN
);
  logic [WIDTH-1:0] latQ, latNext, clrEff, pendVec;
  logic             irqAny;

  always_comb begin
    clrEff  = strb.clrValid ? clrMask : '0;
    // set wins over clear (R4)
    latNext = STICKY_MASK & (evtIn | (latQ & ~clrEff));
    pendVec = latQ & enQ;
    irqAny  = |pendVec;
    rdData  = (latQ & STICKY_MASK) | (condIn & ~STICKY_MASK);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latQ <= '0;
      enQ  <= '0;
      intN <= 1'b1;
    end else begin
      latQ <= latNext;
      if (strb.enLoad) enQ <= enData;
      intN <= ~irqAny;
    end
  end

  // per sticky bit checks
  for (genvar i = 0; i < WIDTH; i++) begin : g_chk
    if (STICKY_MASK[i]) begin : g_sticky
      p_set_r1: assert property (@(posedge clk) disable iff (!rstN)
        evtIn[i] |=> rdData[i]);
      p_ack_r2: assert property (@(posedge clk) disable iff (!rstN)
        (strb.clrValid && clrMask[i] && !evtIn[i]) |=> !rdData[i]);
      p_keep_r2: assert property (@(posedge clk) disable iff (!rstN)
        (rdData[i] && !(strb.clrValid && clrMask[i])) |=> rdData[i]);
      p_no_reset_r3: assert property (@(posedge clk) disable iff (!rstN)
        (!rdData[i] && !evtIn[i]) |=> !rdData[i]);
    end
  end

  p_irq_low_r8: assert property (@(posedge clk) disable iff (!rstN)
    (|(rdData & STICKY_MASK & enQ)) |=> !intN);
  p_irq_high_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(|(rdData & STICKY_MASK & enQ)) |=> intN);
endmodule

// File: rtl/stat_irq_top.sv
module stat_irq_top
  import stat_irq_pkg::*;
#(
  parameter int unsigned WIDTH = 8,
  parameter logic [WIDTH-1:0] STICKY_MASK = 8'hF0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] evtIn,
  input  logic [WIDTH-1:0] condIn,
  input  logic             ackWr,
  input  logic [WIDTH-1:0] ackData,
  input  logic             enWr,
  input  logic [WIDTH-1:0] enData,
  output logic [WIDTH-1:0] rdData,
  output logic [WIDTH-1:0] enQ,
  output logic             intN
);
  statStrobe_t      strb;
  logic [WIDTH-1:0] clrMask;

  stat_irq_ctrl #(.WIDTH(WIDTH), .STICKY_MASK(STICKY_MASK)) ctrl_i (
    .ackWr(ackWr), .ackData(ackData), .enWr(enWr),
    .strb(strb), .clrMask(clrMask)
  );

  stat_irq_dp #(.WIDTH(WIDTH), .STICKY_MASK(STICKY_MASK)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .clrMask(clrMask),
    .evtIn(evtIn), .condIn(condIn), .enData(enData),
    .rdData(rdData), .enQ(enQ), .intN(intN)
  );
endmodule

// File: tb/stat_irq_top_tb.sv
module stat_irq_top_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] evtIn = '0, condIn = '0, ackData = '0, enData = '0;
  logic       ackWr = 1'b0, enWr = 1'b0;
  logic [7:0] rdData, enQ;
  logic       intN;
  int         total = 0, bad = 0;
  bit         finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  stat_irq_top dut_i (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .condIn(condIn),
    .ackWr(ackWr), .ackData(ackData), .enWr(enWr), .enData(enData),
    .rdData(rdData), .enQ(enQ), .intN(intN)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(); @(posedge clk); @(negedge clk); endtask

  task automatic pulseEvt(logic [7:0] m);
    evtIn = m; tick(); evtIn = '0;
  endtask

  task automatic ack(logic [7:0] m);
    ackData = m; ackWr = 1'b1; tick(); ackWr = 1'b0; ackData = '0;
  endtask

  task automatic setEn(logic [7:0] m);
    enData = m; enWr = 1'b1; tick(); enWr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R10 status", rdData, 8'h00);
    chk("R10 enable", enQ, 8'h00);
    chk("R10 intN", {7'd0, intN}, 8'h01);
  endtask

  task automatic t_set_clear();
    pulseEvt(8'h50);
    chk("R1 set", rdData, 8'h50);
    tick();
    chk("R1 held", rdData, 8'h50);
    ack(8'h10);
    chk("R2 partial clear", rdData, 8'h40);
    tick(); tick();
    chk("R3 stays clear", rdData, 8'h40);
    ack(8'hFF);
    chk("R2 full clear", rdData, 8'h00);
    pulseEvt(8'h10);
    chk("R3 re-set by event", rdData, 8'h10);
    ack(8'h10);
  endtask

  task automatic t_live();
    condIn = 8'h0A; #1;
    chk("R5 mirror", rdData, 8'h0A);
    condIn = 8'h05; #1;
    chk("R5 no history", rdData, 8'h05);
    ack(8'h0F);
    chk("R5 write ignored", rdData, 8'h05);
    evtIn = 8'h0F; tick(); evtIn = '0; condIn = 8'h00; #1;
    chk("R6 low bits not sticky", rdData, 8'h00);
  endtask

  task automatic t_collide();
    pulseEvt(8'h30);
    evtIn = 8'h20; ackData = 8'h30; ackWr = 1'b1;
    tick();
    evtIn = '0; ackWr = 1'b0; ackData = '0;
    chk("R4 set beats clear", rdData, 8'h20);
    ack(8'h20);
    chk("R4 cleared after", rdData, 8'h00);
  endtask

  task automatic t_irq();
    setEn(8'h80);
    chk("R7 enable load", enQ, 8'h80);
    pulseEvt(8'h40);
    tick();
    chk("R8 disabled event", {7'd0, intN}, 8'h01);
    pulseEvt(8'h80);
    chk("R8 one edge later still high", {7'd0, intN}, 8'h01);
    tick();
    chk("R8 low", {7'd0, intN}, 8'h00);
    ack(8'h80);
    chk("R9 not yet high", {7'd0, intN}, 8'h00);
    tick();
    chk("R9 release with disabled pending", {7'd0, intN}, 8'h01);
    chk("R9 disabled bit kept", rdData, 8'h40);
    setEn(8'h40);
    tick();
    chk("R8 enabling pending bit", {7'd0, intN}, 8'h00);
    setEn(8'h00);
    tick();
    chk("R9 release by disable", {7'd0, intN}, 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    tick();
    t_set_clear();
    t_live();
    t_collide();
    t_irq();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule